// File: doc/BRIEF.md
# Prescaled Reload Timer with Leveled Interrupt

This block is a down-counting timer for a peripheral subsystem. An input tick drives a prescaler. Each time the prescaler passes zero, the main counter takes one step. When the main counter steps from zero, it reloads from a shadow reload register and records an interrupt request. A byte-wide register bus gives software access to the counter bytes, a run control, a mode byte, a prescale byte and an interrupt-control byte.

The request is held in the interrupt-control register next to a 3-bit priority level. A priority comparator raises the interrupt output when three things hold: the processor's interrupt enable is set, a request is pending, and the level is strictly above the processor's current priority level. A pending request is removed by an acknowledge pulse or by any software write to the interrupt-control register.

The bus is plain control: a write takes effect at the clock edge where `bus_wr` is high, and `bus_rdata` is a combinational view of the register that `bus_addr` selects. No back-pressure exists. With the default parameters the map is: 0 counter low byte, 1 counter high byte, 2 run, 3 mode, 4 prescale, 5 interrupt control. Unmapped addresses read as zero.

Top module: `rld_timer`

## Requirements
- R1: After reset, every register reads zero and `irq_req` is low.
- R2: The prescaler and the counter change only on cycles where `tick` is high and bit 0 of the run register (address 2) is 1. Otherwise both hold their values.
- R3: On each advancing tick the prescaler decrements. When it is zero, it instead reloads and the counter takes one step. A prescale reload of P therefore gives one counter step every P+1 ticks.
- R4: With WIDE_SEL=1, mode bits 7:6 select the prescale reload: 00 gives 0, 01 gives 8, 10 gives the low nibble of the prescale register, and 11 gives 32. With WIDE_SEL=0, the reload is the whole prescale register.
- R5: A write to a counter byte (address 0 low, address 1 high) replaces that byte and copies the merged counter into the reload register. That write takes precedence over a step in the same cycle, and that step is lost.
- R6: A counter step from a nonzero value decrements the counter. A step from zero loads the reload register and counts as an underflow.
- R7: On an underflow, if the level field (interrupt-control bits 2:0) is nonzero, the request bit (bit 3) is set. If the level is zero, nothing is recorded.
- R8: The request bit is cleared by an `irq_ack` pulse or by any write to address 5, whatever value is written to bit 3. An underflow in the same cycle wins over the clear, and a same-cycle write supplies the level that decides it.
- R9: `irq_req` is high exactly when `irq_en` is 1, the request bit is 1, and the level is strictly greater than `cpu_ipl`.
- R10: Reads of addresses 0 and 1 return the live counter, not the reload value. Address 5 reads as {4'b0, request, level}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count pulse for the prescaler |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| irq_en | input | 1 | Processor interrupt-enable flag |
| cpu_ipl | input | 3 | Current processor priority level |
| irq_ack | input | 1 | Interrupt acknowledge pulse, clears the request |
| irq_req | output | 1 | Interrupt request to the processor |

## Verification
Two collisions decide this block's correctness. The first is an underflow landing in the same cycle as a request clear, either from `irq_ack` or from a write to the interrupt-control register. The second is a counter step landing in the same cycle as a counter-byte write. The bench parks the counter at zero with the prescale at 0, then raises `tick` together with the acknowledge or the write on the same edge. It judges the outcome from the interrupt-control readback, which must show the request set, with the freshly written level for the write case. For the step collision, the counter readback must equal the written byte and show no decrement. A behavioural model that runs alongside compares every readback and the interrupt output on every clock, through random traffic that reaches these collisions again.

// File: rtl/rld_timer_pkg.sv
package rld_timer_pkg;

  localparam int BUS_W = 8;

  // Control registers follow the counter bytes in the address map;
  // these are offsets from the first address past the counter.
  typedef enum logic [1:0] {
    CTL_RUN  = 2'd0,
    CTL_MODE = 2'd1,
    CTL_PSC  = 2'd2,
    CTL_ICTL = 2'd3
  } ctl_off_e;

endpackage

// File: rtl/rld_timer_presc.sv
module rld_timer_presc #(
  parameter int PSC_W    = 8,
  parameter int WIDE_SEL = 1,
  parameter int FIX_LO   = 8,
  parameter int FIX_HI   = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance,
  input  logic [1:0]       mode_sel,
  input  logic [PSC_W-1:0] psc_reg,
  output logic [PSC_W-1:0] pre_q,
  output logic             step
);

  logic [PSC_W-1:0] reload_val;

  generate
    if (WIDE_SEL != 0) begin : g_wide
      always_comb begin
        case (mode_sel)
          2'b00:   reload_val = '0;
          2'b01:   reload_val = PSC_W'(FIX_LO);
          2'b10:   reload_val = psc_reg & PSC_W'(4'hF);
          default: reload_val = PSC_W'(FIX_HI);
        endcase
      end
    end else begin : g_narrow
      assign reload_val = psc_reg;
    end
  endgenerate

  assign step = advance && (pre_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else if (advance) begin
      pre_q <= step ? reload_val : pre_q - 1'b1;
    end
  end

endmodule

// File: rtl/rld_timer_count.sv
module rld_timer_count #(
  parameter int CNT_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    step,
  input  logic [CNT_W/BYTE_W-1:0] wr_sel,
  input  logic [BYTE_W-1:0]       wr_byte,
  output logic [CNT_W-1:0]        cnt_q,
  output logic [CNT_W-1:0]        reload_q,
  output logic                    underflow
);

  localparam int NBYTES = CNT_W / BYTE_W;

  logic [CNT_W-1:0] merged;
  logic             wr_any;

  generate
    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
      assign merged[b*BYTE_W +: BYTE_W] = wr_sel[b] ? wr_byte
                                                    : cnt_q[b*BYTE_W +: BYTE_W];
    end
  endgenerate

  assign wr_any    = |wr_sel;
  assign underflow = step && !wr_any && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      reload_q <= '0;
    end else if (wr_any) begin
      cnt_q    <= merged;
      reload_q <= merged;
    end else if (step) begin
      cnt_q <= (cnt_q == '0) ? reload_q : cnt_q - 1'b1;
    end
  end

endmodule

// File: rtl/rld_timer_irq.sv
module rld_timer_irq #(
  parameter int LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [LVL_W-1:0] wr_lvl,
  input  logic             underflow,
  input  logic             ack,
  input  logic             irq_en,
  input  logic [LVL_W-1:0] cpu_ipl,
  output logic [LVL_W-1:0] lvl_q,
  output logic             req_q,
  output logic             irq_req
);

  logic [LVL_W-1:0] lvl_next;

  assign lvl_next = wr_en ? wr_lvl : lvl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q <= '0;
      req_q <= 1'b0;
    end else begin
      lvl_q <= lvl_next;
      if (underflow && (lvl_next != '0)) begin
        req_q <= 1'b1;
      end else if (wr_en || ack) begin
        req_q <= 1'b0;
      end
    end
  end

  assign irq_req = irq_en && req_q && (lvl_q > cpu_ipl);

endmodule

// File: rtl/rld_timer.sv
module rld_timer
  import rld_timer_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int PSC_W      = 8,
  parameter int LVL_W      = 3,
  parameter int ADDR_W     = 3,
  parameter int WIDE_SEL   = 1,
  parameter int MODE_LSB   = 6,
  parameter int PSC_FIX_LO = 8,
  parameter int PSC_FIX_HI = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              irq_en,
  input  logic [LVL_W-1:0]  cpu_ipl,
  input  logic              irq_ack,
  output logic              irq_req
);

  localparam int CNT_BYTES = CNT_W / BUS_W;
  localparam logic [ADDR_W-1:0] A_RUN  = ADDR_W'(CNT_BYTES + int'(CTL_RUN));
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(CNT_BYTES + int'(CTL_MODE));
  localparam logic [ADDR_W-1:0] A_PSC  = ADDR_W'(CNT_BYTES + int'(CTL_PSC));
  localparam logic [ADDR_W-1:0] A_ICTL = ADDR_W'(CNT_BYTES + int'(CTL_ICTL));

  logic                 run_q;
  logic [BUS_W-1:0]     mode_q;
  logic [PSC_W-1:0]     psc_q;
  logic [CNT_BYTES-1:0] cnt_sel;
  logic                 wr_ictl;
  logic                 advance;
  logic                 step;
  logic                 underflow;
  logic [PSC_W-1:0]     pre_q;
  logic [CNT_W-1:0]     cnt_q;
  logic [CNT_W-1:0]     reload_q;
  logic [LVL_W-1:0]     lvl_q;
  logic                 req_q;

  generate
    for (genvar b = 0; b < CNT_BYTES; b++) begin : g_sel
      assign cnt_sel[b] = bus_wr && (bus_addr == ADDR_W'(b));
    end
  endgenerate

  assign wr_ictl = bus_wr && (bus_addr == A_ICTL);
  assign advance = run_q && tick;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      mode_q <= '0;
      psc_q  <= '0;
    end else if (bus_wr) begin
      if (bus_addr == A_RUN)  run_q  <= bus_wdata[0];
      if (bus_addr == A_MODE) mode_q <= bus_wdata;
      if (bus_addr == A_PSC)  psc_q  <= bus_wdata[PSC_W-1:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    for (int b = 0; b < CNT_BYTES; b++) begin
      if (bus_addr == ADDR_W'(b)) bus_rdata = cnt_q[b*BUS_W +: BUS_W];
    end
    case (bus_addr)
      A_RUN:   bus_rdata = {{(BUS_W-1){1'b0}}, run_q};
      A_MODE:  bus_rdata = mode_q;
      A_PSC:   bus_rdata = BUS_W'(psc_q);
      A_ICTL:  bus_rdata = BUS_W'({req_q, lvl_q});
      default: ;
    endcase
  end

  rld_timer_presc #(
    .PSC_W   (PSC_W),
    .WIDE_SEL(WIDE_SEL),
    .FIX_LO  (PSC_FIX_LO),
    .FIX_HI  (PSC_FIX_HI)
  ) u_presc (
    .clk     (clk),
    .rst_n   (rst_n),
    .advance (advance),
    .mode_sel(mode_q[MODE_LSB +: 2]),
    .psc_reg (psc_q),
    .pre_q   (pre_q),
    .step    (step)
  );

  rld_timer_count #(
    .CNT_W (CNT_W),
    .BYTE_W(BUS_W)
  ) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (step),
    .wr_sel   (cnt_sel),
    .wr_byte  (bus_wdata),
    .cnt_q    (cnt_q),
    .reload_q (reload_q),
    .underflow(underflow)
  );

  rld_timer_irq #(
    .LVL_W(LVL_W)
  ) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_ictl),
    .wr_lvl   (bus_wdata[LVL_W-1:0]),
    .underflow(underflow),
    .ack      (irq_ack),
    .irq_en   (irq_en),
    .cpu_ipl  (cpu_ipl),
    .lvl_q    (lvl_q),
    .req_q    (req_q),
    .irq_req  (irq_req)
  );

endmodule

// File: rtl/rld_timer_chk.sv
module rld_timer_chk
  import rld_timer_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int PSC_W     = 8,
  parameter int LVL_W     = 3,
  parameter int ADDR_W    = 3,
  parameter int CNT_BYTES = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              irq_ack,
  input logic [LVL_W-1:0]  cpu_ipl,
  input logic              irq_req,
  input logic              run_q,
  input logic [PSC_W-1:0]  pre_q,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [CNT_W-1:0]  reload_q,
  input logic [LVL_W-1:0]  lvl_q,
  input logic              req_q
);

  logic cnt_wr, ictl_wr, uf_now;

  assign cnt_wr  = bus_wr && (bus_addr < ADDR_W'(CNT_BYTES));
  assign ictl_wr = bus_wr && (bus_addr == ADDR_W'(CNT_BYTES + int'(CTL_ICTL)));
  assign uf_now  = tick && run_q && (pre_q == '0) && (cnt_q == '0) && !cnt_wr;

  a_r2_count_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!(tick && run_q) && !cnt_wr) |=> $stable(cnt_q));

  a_r2_presc_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !(tick && run_q) |=> $stable(pre_q));

  a_r5_write_copies_reload: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (reload_q == cnt_q));

  a_r6_reload_on_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    uf_now |=> (cnt_q == $past(reload_q)));

  a_r7_level_zero_no_set: assert property (@(posedge clk) disable iff (!rst_n)
    (!ictl_wr && (lvl_q == '0) && !req_q) |=> !req_q);

  a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !uf_now) |=> !req_q);

  a_r8_underflow_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (uf_now && (lvl_q != '0) && !ictl_wr) |=> req_q);

  a_r9_no_irq_at_or_below: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q <= cpu_ipl) |-> !irq_req);

endmodule

bind rld_timer rld_timer_chk #(
  .CNT_W    (CNT_W),
  .PSC_W    (PSC_W),
  .LVL_W    (LVL_W),
  .ADDR_W   (ADDR_W),
  .CNT_BYTES(CNT_BYTES)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .tick    (tick),
  .bus_wr  (bus_wr),
  .bus_addr(bus_addr),
  .irq_ack (irq_ack),
  .cpu_ipl (cpu_ipl),
  .irq_req (irq_req),
  .run_q   (run_q),
  .pre_q   (pre_q),
  .cnt_q   (cnt_q),
  .reload_q(reload_q),
  .lvl_q   (lvl_q),
  .req_q   (req_q)
);

// File: tb/rld_timer_tb_top.sv
`timescale 1ns/1ps
module rld_timer_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       bus_wr = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq_en = 1'b0;
  logic [2:0] cpu_ipl = '0;
  logic       irq_ack = 1'b0;
  logic       irq_req;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  // behavioural reference state
  int m_cnt, m_rel, m_pre, m_run, m_mode, m_psc, m_lvl, m_req;

  always #10 clk = ~clk;

  rld_timer dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_en(irq_en), .cpu_ipl(cpu_ipl), .irq_ack(irq_ack), .irq_req(irq_req)
  );

  function automatic int psc_reload(int mode, int psc);
    case ((mode >> 6) & 3)
      0: return 0;
      1: return 8;
      2: return psc & 15;
      default: return 32;
    endcase
  endfunction

  function automatic int m_read(int a);
    case (a)
      0: return m_cnt & 255;
      1: return (m_cnt >> 8) & 255;
      2: return m_run;
      3: return m_mode;
      4: return m_psc;
      5: return m_req * 8 + m_lvl;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    int nl;
    bit st, uf, cw, iw;
    if (!rst_n) begin
      m_cnt = 0; m_rel = 0; m_pre = 0; m_run = 0;
      m_mode = 0; m_psc = 0; m_lvl = 0; m_req = 0;
    end else begin
      st = 0; uf = 0;
      cw = bus_wr && (bus_addr < 2);
      iw = bus_wr && (bus_addr == 5);
      if (m_run != 0 && tick) begin
        if (m_pre == 0) begin
          m_pre = psc_reload(m_mode, m_psc);
          st = 1;
        end else m_pre = m_pre - 1;
      end
      if (cw) begin
        if (bus_addr == 0) m_cnt = (m_cnt & 'hFF00) | int'(bus_wdata);
        else               m_cnt = (m_cnt & 'h00FF) | (int'(bus_wdata) << 8);
        m_rel = m_cnt;
      end else if (st) begin
        if (m_cnt == 0) begin
          m_cnt = m_rel;
          uf = 1;
        end else m_cnt = m_cnt - 1;
      end
      nl = iw ? (int'(bus_wdata) & 7) : m_lvl;
      if (uf && nl != 0) m_req = 1;
      else if (iw || irq_ack) m_req = 0;
      m_lvl = nl;
      if (bus_wr) begin
        case (bus_addr)
          3'd2: m_run = int'(bus_wdata) & 1;
          3'd3: m_mode = int'(bus_wdata);
          3'd4: m_psc = int'(bus_wdata);
          default: ;
        endcase
      end
    end
  end

  task automatic check(string req, int got, int exp);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", req, got, exp, $time);
    end
  endtask

  // continuous comparison against the model, mid-cycle
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R10 readback vs model", int'(bus_rdata), m_read(int'(bus_addr)));
      check("R9 irq vs model", int'(irq_req),
            (irq_en && m_req != 0 && m_lvl > int'(cpu_ipl)) ? 1 : 0);
    end
  end

  task automatic wr(int a, int d);
    @(posedge clk); #1;
    bus_wr = 1'b1; bus_addr = 3'(a); bus_wdata = 8'(d);
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(int a, output int v);
    @(posedge clk); #1;
    bus_addr = 3'(a);
    @(negedge clk);
    v = int'(bus_rdata);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      tick = 1'b1;
    end
    @(posedge clk); #1;
    tick = 1'b0;
  endtask

  task automatic set_irq(bit en, int ipl);
    @(posedge clk); #1;
    irq_en = en; cpu_ipl = 3'(ipl);
    @(negedge clk);
  endtask

  task automatic expect_rd(string req, int a, int exp);
    int v;
    rd(a, v);
    check(req, v, exp);
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #3_000_000;
    n_fail++;
    $display("FAIL watchdog (all requirements): got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 6; a++) expect_rd("R1 reset value", a, 0);
    check("R1 irq after reset", int'(irq_req), 0);

    // R5 / R10 counter byte writes and live readback
    wr(0, 'h34);
    wr(1, 'h12);
    expect_rd("R10 count low", 0, 'h34);
    expect_rd("R10 count high", 1, 'h12);

    // R2 stopped timer ignores ticks
    ticks(5);
    expect_rd("R2 stopped low", 0, 'h34);
    expect_rd("R2 stopped high", 1, 'h12);

    // R3 / R4 mode 00: prescale 0, one step per tick
    wr(2, 1);
    ticks(4);
    expect_rd("R3 step per tick", 0, 'h30);

    // R4 mode 01: reload 8
    wr(3, 'h40);
    ticks(1);
    expect_rd("R4 mode01 first step", 0, 'h2F);
    ticks(8);
    expect_rd("R4 mode01 prescaling", 0, 'h2F);
    ticks(1);
    expect_rd("R4 mode01 ninth tick", 0, 'h2E);

    // R4 mode 10: low nibble of prescale register
    wr(4, 'hF3);
    wr(3, 'h80);
    ticks(8);
    expect_rd("R4 drain previous prescale", 0, 'h2E);
    ticks(1);
    expect_rd("R4 mode10 step", 0, 'h2D);
    ticks(3);
    expect_rd("R4 mode10 nibble hold", 0, 'h2D);
    ticks(1);
    expect_rd("R4 mode10 step after nibble", 0, 'h2C);

    // R4 mode 11: reload 32
    wr(3, 'hC0);
    ticks(3);
    ticks(1);
    expect_rd("R4 mode11 step", 0, 'h2B);
    ticks(32);
    expect_rd("R4 mode11 hold", 0, 'h2B);
    ticks(1);
    expect_rd("R4 mode11 step after 33", 0, 'h2A);
    wr(3, 'h00);
    ticks(33);
    expect_rd("R3 back to prescale 0", 0, 'h29);
    expect_rd("R10 high byte live", 1, 'h12);

    // R6 / R7 / R9 underflow and request
    wr(2, 0);
    wr(0, 2);
    wr(1, 0);
    wr(5, 5);
    set_irq(1, 2);
    wr(2, 1);
    ticks(2);
    expect_rd("R6 counted to zero", 0, 0);
    expect_rd("R7 no request before underflow", 5, 'h05);
    ticks(1);
    expect_rd("R6 reload after zero", 0, 2);
    expect_rd("R7 request set", 5, 'h0D);
    check("R9 irq level above ipl", int'(irq_req), 1);
    set_irq(1, 5);
    check("R9 irq level equal ipl", int'(irq_req), 0);
    set_irq(1, 4);
    check("R9 irq level one above", int'(irq_req), 1);
    set_irq(0, 4);
    check("R9 irq disabled", int'(irq_req), 0);
    set_irq(1, 2);

    // R8 acknowledge clears
    @(posedge clk); #1 irq_ack = 1'b1;
    @(posedge clk); #1 irq_ack = 1'b0;
    expect_rd("R8 ack clears request", 5, 'h05);
    check("R8 irq after ack", int'(irq_req), 0);

    // R7 level zero records nothing
    wr(5, 0);
    ticks(3);
    expect_rd("R7 level zero count reloaded", 0, 2);
    expect_rd("R7 level zero no request", 5, 'h00);

    // R8 underflow and ack in same cycle
    wr(5, 6);
    ticks(2);
    @(posedge clk); #1 tick = 1'b1; irq_ack = 1'b1;
    @(posedge clk); #1 tick = 1'b0; irq_ack = 1'b0;
    expect_rd("R8 underflow beats ack", 5, 'h0E);
    expect_rd("R6 reload in collision", 0, 2);

    // R8 underflow and control write in same cycle
    ticks(2);
    @(posedge clk); #1 tick = 1'b1; bus_wr = 1'b1; bus_addr = 3'd5; bus_wdata = 8'h03;
    @(posedge clk); #1 tick = 1'b0; bus_wr = 1'b0;
    expect_rd("R8 underflow beats write, new level", 5, 'h0B);

    // R8 writing bit 3 does not set the request
    wr(5, 'h0C);
    expect_rd("R8 write clears regardless of bit3", 5, 'h04);

    // R5 count write beats a step
    @(posedge clk); #1 tick = 1'b1; bus_wr = 1'b1; bus_addr = 3'd0; bus_wdata = 8'h77;
    @(posedge clk); #1 tick = 1'b0; bus_wr = 1'b0;
    expect_rd("R5 write wins over step low", 0, 'h77);
    expect_rd("R5 write wins over step high", 1, 0);

    // random traffic against the model (R2..R10)
    for (int i = 0; i < 3000; i++) begin
      @(posedge clk); #1;
      tick     = ($urandom % 2) == 0;
      bus_wr   = ($urandom % 6) == 0;
      bus_addr = 3'($urandom % 7);
      bus_wdata = 8'($urandom);
      if (bus_addr == 3'd1) bus_wdata = 8'h00;
      if (bus_addr == 3'd0) bus_wdata = bus_wdata & 8'h0F;
      if (bus_addr == 3'd2 && ($urandom % 4) != 0) bus_wdata[0] = 1'b1;
      if (bus_addr == 3'd3 && ($urandom % 2) == 0) bus_wdata[7:6] = 2'b00;
      irq_ack  = ($urandom % 16) == 0;
      irq_en   = ($urandom % 4) != 0;
      cpu_ipl  = 3'($urandom);
    end
    @(posedge clk); #1;
    tick = 1'b0; bus_wr = 1'b0; irq_ack = 1'b0;
    @(negedge clk);
    finish_run();
  end

endmodule